// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block holds the pointer state for a circular ring of 16-byte receive descriptors that live in host memory. Software programs a 64-bit ring base, a ring length in bytes, a starting head index and a tail index through a small register port. The receive datapath pulses `desc_done` each time it finishes with a descriptor. The block answers with the host byte address of the descriptor now in use, the number of descriptors still available to hardware, and a ready flag.

Two head indices are kept. The shadow head moves on every accepted completion and addresses the next descriptor. The visible head, which software reads back, moves only when a writeback report says that completed descriptors have reached memory. It never overtakes the shadow head. Ring geometry is locked while receive is enabled. Only the tail may change during traffic.

Register indices on `reg_addr` / `reg_raddr`: 0 base bits 31:0, 1 base bits 63:32, 2 length in bytes, 3 head, 4 tail. All other indices read zero and ignore writes.

Top module: `rx_ring_ctrl`

## Requirements
- R1: The base is written as a low word at index 0 and a high word at index 1. Bits 3:0 of the low word are discarded and always read back as zero.
- R2: `desc_addr` equals the aligned base plus 16 times the shadow head, so its low 4 bits are always zero.
- R3: `len_ok` is 1 only when the length is nonzero, a multiple of 128, and no more than 524160 bytes (32760 descriptors). The ring holds length/16 descriptors.
- R4: While enabled with a valid length, an accepted `desc_done` advances the shadow head by one in the next cycle. The index wraps to 0 on reaching length/16.
- R5: `avail_cnt` equals (tail − shadow head) mod ring size. `ring_ready` is 1 exactly when `rx_enable`, `len_ok` and a nonzero `avail_cnt` all hold.
- R6: A `desc_done` while enabled with `avail_cnt` zero leaves the shadow head unchanged and sets `ring_err`. `ring_err` stays set until reset.
- R7: A `wb_valid` pulse advances the visible head by `wb_count`, modulo the ring size. The step is capped at the number of descriptors between the visible head and the shadow head.
- R8: Writes to base, length or head are ignored while `rx_enable` is 1. Tail writes take effect at any time.
- R9: A head write while disabled loads both the visible head and the shadow head.
- R10: After reset, all registers read zero, and `len_ok`, `ring_ready`, `ring_err` and `avail_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enabled; locks ring geometry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write register index |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read register index |
| reg_rdata | output | 32 | Read data (combinational) |
| desc_done | input | 1 | Descriptor completed pulse |
| wb_valid | input | 1 | Writeback report strobe |
| wb_count | input | IDX_W | Descriptors written back |
| desc_addr | output | 64 | Host byte address of current descriptor |
| avail_cnt | output | IDX_W | Descriptors available to hardware |
| ring_ready | output | 1 | Hardware may use a descriptor |
| len_ok | output | 1 | Programmed length is legal |
| ring_err | output | 1 | Sticky completion-on-empty flag |

## Verification
The assertions check four properties on every cycle. The descriptor address stays 16-byte aligned. The error flag never clears. Ring geometry cannot move while receive is enabled. The visible head moves only on a writeback report or a head write, and a completion on an empty ring never moves the shadow head.

Only the bench scenarios can show the arithmetic itself. That covers the modulo available count as the tail moves, the wrap of both heads at length/16, and the capping of writeback steps at the shadow head. It also covers the legality window for lengths and the read-back of the masked base bits.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int IDX_W    = 15,
  parameter int MAX_DESC = 32760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [2:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  input  logic             desc_done,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_count,
  output logic [63:0]      desc_addr,
  output logic [IDX_W-1:0] avail_cnt,
  output logic             ring_ready,
  output logic             len_ok,
  output logic             ring_err
);
  localparam logic [31:0] LEN_MAX = 32'(MAX_DESC) * 32'd16;
  localparam int PAD_W = 32 - IDX_W;

  logic [31:4]      base_lo_q;
  logic [31:0]      base_hi_q;
  logic [31:0]      len_q;
  logic [IDX_W-1:0] head_q, shadow_q, tail_q;
  logic             err_q;

  logic [IDX_W-1:0] ring_size;
  logic [IDX_W-1:0] pending;
  logic [IDX_W-1:0] wb_step;
  logic             take_done;

  function automatic logic [IDX_W-1:0] ring_add(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] n,
                                                input logic [IDX_W-1:0] sz);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, n};
    if (s >= {1'b0, sz}) s = s - {1'b0, sz};
    return s[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] ring_sub(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] b,
                                                input logic [IDX_W-1:0] sz);
    if (a >= b) return a - b;
    return a + sz - b;
  endfunction

  assign len_ok    = (len_q[6:0] == 7'd0) && (len_q != 32'd0) && (len_q <= LEN_MAX);
  assign ring_size = len_q[IDX_W+3:4];
  assign avail_cnt = len_ok ? ring_sub(tail_q, shadow_q, ring_size) : '0;
  assign pending   = len_ok ? ring_sub(shadow_q, head_q, ring_size) : '0;
  assign wb_step   = (wb_count > pending) ? pending : wb_count;
  assign ring_ready = rx_enable && len_ok && (avail_cnt != '0);
  assign take_done  = desc_done && ring_ready;
  assign ring_err   = err_q;
  assign desc_addr  = {base_hi_q, base_lo_q, 4'h0} + {{(60-IDX_W){1'b0}}, shadow_q, 4'h0};

  always_comb begin
    unique case (reg_raddr)
      3'd0:    reg_rdata = {base_lo_q, 4'h0};
      3'd1:    reg_rdata = base_hi_q;
      3'd2:    reg_rdata = len_q;
      3'd3:    reg_rdata = {{PAD_W{1'b0}}, head_q};
      3'd4:    reg_rdata = {{PAD_W{1'b0}}, tail_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      len_q     <= '0;
      head_q    <= '0;
      shadow_q  <= '0;
      tail_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      if (reg_wr && !rx_enable) begin
        unique case (reg_addr)
          3'd0: base_lo_q <= reg_wdata[31:4];
          3'd1: base_hi_q <= reg_wdata;
          3'd2: len_q     <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 3'd4)
        tail_q <= reg_wdata[IDX_W-1:0];

      if (reg_wr && !rx_enable && reg_addr == 3'd3) begin
        head_q   <= reg_wdata[IDX_W-1:0];
        shadow_q <= reg_wdata[IDX_W-1:0];
      end else begin
        if (take_done)
          shadow_q <= ring_add(shadow_q, {{(IDX_W-1){1'b0}}, 1'b1}, ring_size);
        if (wb_valid && len_ok)
          head_q <= ring_add(head_q, wb_step, ring_size);
      end

      if (desc_done && rx_enable && len_ok && avail_cnt == '0)
        err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_ctrl_chk.sv
module rx_ring_ctrl_chk #(
  parameter int IDX_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             desc_done,
  input logic             wb_valid,
  input logic [63:0]      desc_addr,
  input logic [IDX_W-1:0] avail_cnt,
  input logic             len_ok,
  input logic             ring_err,
  input logic [31:0]      len_q,
  input logic [31:0]      base_hi_q,
  input logic [IDX_W-1:0] head_q,
  input logic [IDX_W-1:0] shadow_q
);
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_addr[3:0] == 4'h0);  // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ring_err |=> ring_err);  // R6

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && rx_enable && len_ok && avail_cnt == '0) |=> (ring_err && $stable(shadow_q)));  // R6

  AST_GEOM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> ($stable(len_q) && $stable(base_hi_q)));  // R8

  AST_HEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_valid && !(reg_wr && reg_addr == 3'd3)) |=> $stable(head_q));  // R7
endmodule

bind rx_ring_ctrl rx_ring_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .desc_done(desc_done), .wb_valid(wb_valid),
  .desc_addr(desc_addr), .avail_cnt(avail_cnt), .len_ok(len_ok),
  .ring_err(ring_err), .len_q(len_q), .base_hi_q(base_hi_q),
  .head_q(head_q), .shadow_q(shadow_q)
);

// File: tb/rx_ring_ctrl_tb_top.sv
module rx_ring_ctrl_tb_top;
  localparam int IDX_W = 15;
  localparam logic [63:0] BASE = 64'h1234_5678_9ABC_DEF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0] reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic desc_done = 1'b0;
  logic wb_valid = 1'b0;
  logic [IDX_W-1:0] wb_count = '0;
  logic [63:0] desc_addr;
  logic [IDX_W-1:0] avail_cnt;
  logic ring_ready, len_ok, ring_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_ring_ctrl #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .desc_done(desc_done), .wb_valid(wb_valid),
    .wb_count(wb_count), .desc_addr(desc_addr), .avail_cnt(avail_cnt),
    .ring_ready(ring_ready), .len_ok(len_ok), .ring_err(ring_err)
  );

  // op[33:32]: 0 completion, 1 writeback(arg), 2 tail write(arg)
  // arg[31:24], expected shadow[23:16], avail[15:8], head[7:0]; ring of 8
  localparam logic [33:0] VEC [14] = '{
    {2'd0, 8'd0, 8'd1, 8'd4, 8'd0},
    {2'd0, 8'd0, 8'd2, 8'd3, 8'd0},
    {2'd1, 8'd1, 8'd2, 8'd3, 8'd1},
    {2'd1, 8'd5, 8'd2, 8'd3, 8'd2},
    {2'd0, 8'd0, 8'd3, 8'd2, 8'd2},
    {2'd0, 8'd0, 8'd4, 8'd1, 8'd2},
    {2'd0, 8'd0, 8'd5, 8'd0, 8'd2},
    {2'd0, 8'd0, 8'd5, 8'd0, 8'd2},
    {2'd2, 8'd2, 8'd5, 8'd5, 8'd2},
    {2'd0, 8'd0, 8'd6, 8'd4, 8'd2},
    {2'd0, 8'd0, 8'd7, 8'd3, 8'd2},
    {2'd0, 8'd0, 8'd0, 8'd2, 8'd2},
    {2'd1, 8'd6, 8'd0, 8'd2, 8'd0},
    {2'd0, 8'd0, 8'd1, 8'd1, 8'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d);
      check("R10 reg", 64'(d), 64'd0);
    end
    check("R10 len_ok", 64'(len_ok), 64'd0);
    check("R10 ready", 64'(ring_ready), 64'd0);
    check("R10 err", 64'(ring_err), 64'd0);
    check("R10 avail", 64'(avail_cnt), 64'd0);

    // R1 base with dirty low bits
    wr(3'd0, 32'h9ABC_DEF7);
    wr(3'd1, 32'h1234_5678);
    rd(3'd0, d); check("R1 base low", 64'(d), 64'h9ABC_DEF0);
    rd(3'd1, d); check("R1 base high", 64'(d), 64'h1234_5678);

    // R3 length legality
    wr(3'd2, 32'd100);    check("R3 len 100", 64'(len_ok), 64'd0);
    wr(3'd2, 32'd0);      check("R3 len 0", 64'(len_ok), 64'd0);
    wr(3'd2, 32'd524288); check("R3 len over", 64'(len_ok), 64'd0);
    wr(3'd2, 32'd524160); check("R3 len max", 64'(len_ok), 64'd1);
    wr(3'd2, 32'd128);    check("R3 len 128", 64'(len_ok), 64'd1);

    wr(3'd3, 32'd0);
    wr(3'd4, 32'd5);
    check("R5 ready disabled", 64'(ring_ready), 64'd0);
    check("R2 addr start", desc_addr, BASE);
    @(negedge clk);
    rx_enable = 1'b1;
    #1;
    check("R5 ready enabled", 64'(ring_ready), 64'd1);
    check("R5 avail start", 64'(avail_cnt), 64'd5);

    // table walk: R4 R5 R6 R7 R2
    foreach (VEC[i]) begin
      @(negedge clk);
      case (VEC[i][33:32])
        2'd0: desc_done = 1'b1;
        2'd1: begin wb_valid = 1'b1; wb_count = IDX_W'(VEC[i][31:24]); end
        default: begin reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'(VEC[i][31:24]); end
      endcase
      @(negedge clk);
      desc_done = 1'b0; wb_valid = 1'b0; reg_wr = 1'b0;
      rd(3'd3, d);
      check("R4/R7 head", 64'(d), 64'(VEC[i][7:0]));
      check("R5 avail", 64'(avail_cnt), 64'(VEC[i][15:8]));
      check("R2/R4 addr", desc_addr, BASE + 64'(VEC[i][23:16]) * 64'd16);
      check("R5 ready", 64'(ring_ready), 64'(VEC[i][15:8] != 8'd0));
      if (i == 6) check("R6 err clear", 64'(ring_err), 64'd0);
      if (i == 7) check("R6 err set", 64'(ring_err), 64'd1);
    end
    check("R6 err sticky", 64'(ring_err), 64'd1);

    // R8 locked writes while enabled, tail still writable
    wr(3'd2, 32'd256);  rd(3'd2, d); check("R8 len locked", 64'(d), 64'd128);
    wr(3'd3, 32'd3);    rd(3'd3, d); check("R8 head locked", 64'(d), 64'd0);
    check("R8 shadow locked", desc_addr, BASE + 64'd16);
    wr(3'd1, 32'hFFFF); rd(3'd1, d); check("R8 base locked", 64'(d), 64'h1234_5678);
    wr(3'd4, 32'd7);    rd(3'd4, d); check("R8 tail live", 64'(d), 64'd7);
    check("R8 avail after tail", 64'(avail_cnt), 64'd6);

    // R9 head write while disabled loads both heads
    @(negedge clk);
    rx_enable = 1'b0;
    wr(3'd3, 32'd4);
    rd(3'd3, d); check("R9 head", 64'(d), 64'd4);
    check("R9 shadow addr", desc_addr, BASE + 64'd64);
    check("R9 avail", 64'(avail_cnt), 64'd3);
    @(negedge clk);
    desc_done = 1'b1;
    @(negedge clk);
    desc_done = 1'b0;
    check("R4 disabled ignore", desc_addr, BASE + 64'd64);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule